// File: doc/BRIEF.md
# Predicated Upper-Half Logic Unit

This block is a single-cycle execution stage for the bitwise operations of a fixed-point signal-processing data path. Each accepted instruction is a pair of 16-bit words. The first word only has to carry the right prefix. The second word selects one of three bitwise functions (AND, OR, XOR) and one of three predication forms. It also picks two source registers and one destination register.

The function works only on the upper 16 bits of the two 32-bit sources. The result goes into the upper half of the destination, and the lower half is written as zero. A single condition flag decides whether the predicated forms run. Only the unpredicated form writes that flag.

Instructions arrive on a valid/ready stream. Ready is held high at all times, so the unit never applies back-pressure, and each instruction is taken on the clock edge where valid is high. A separate plain load port fills the register file. A combinational read port shows any register's contents.

Top module: `dlu_top`

## Requirements
- R1: An instruction is acted on only when in_valid is 1 and bits 15:10 of in_word1 equal 111110. Bits 9:0 of that word are ignored. Any other first word is a no-op and raises no illegal pulse.
- R2: Bits 15:10 of in_word2 select the function: 100101 is AND, 101101 is OR and 101001 is XOR.
- R3: Source X is the register indexed by bits 7:6 of in_word2, and source Y is the register indexed by bits 5:4 (registers 0 to 3). The destination is indexed by bits 3:0.
- R4: An executed operation writes {f(X[31:16], Y[31:16]), 16'h0000} into the destination.
- R5: The predication form sits in bits 9:8 of in_word2. 01 always executes. 10 executes only when flag_o is 1. 11 executes only when flag_o is 0. A predicated form that does not execute leaves all registers and the flag unchanged.
- R6: Only form 01 updates the flag. It sets flag_o to 1 when the 16-bit result is zero and to 0 otherwise. This happens even when the destination code is unused. Forms 10 and 11 never change the flag.
- R7: A destination code of NUM_REGS or above leaves every register unchanged.
- R8: A second word whose function or form code is not listed is a no-op. It makes illegal_o 1 for exactly the one cycle after the accepting edge.
- R9: The result can be read on rd_data right after the accepting edge. in_ready is constantly 1.
- R10: A synchronous active-high reset clears all registers, flag_o and illegal_o.
- R11: ld_en writes ld_data, all 32 bits, into register ld_addr. If an executed operation targets the same register on the same edge, the operation's value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction pair valid |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_word1 | input | 16 | First instruction word (prefix) |
| in_word2 | input | 16 | Second instruction word (operation) |
| ld_en | input | 1 | Register load enable |
| ld_addr | input | AW | Register load index |
| ld_data | input | 32 | Register load value |
| rd_addr | input | AW | Read port index |
| rd_data | output | 32 | Read port value (combinational) |
| flag_o | output | 1 | Condition flag |
| illegal_o | output | 1 | One-cycle pulse for an unknown operation |

## Verification
The bench drives both predicated forms with the flag set and with it clear. A design that swaps the predicate sense, or lets predicated forms write the flag, would leave the wrong register contents or the wrong flag. It forces a zero upper-half result from operands whose lower halves are non-zero. A design that tested all 32 bits for the flag, or did not clear the lower half, would differ there. It also covers the remaining corner cases:
- Unused destinations: a design that wraps the index would corrupt a live register.
- Form code 00: a design that decodes it would write a register instead of pulsing illegal_o.
- A wrong prefix: a design that ignores it would execute.
- A load and an operation hitting the same register on one edge: a design with the wrong priority would keep the loaded value.

// File: rtl/dlu_pkg.sv
package dlu_pkg;
  localparam logic [5:0] PREFIX = 6'b111110;

  typedef enum logic [1:0] {LOP_AND, LOP_OR, LOP_XOR, LOP_NONE} lop_e;
  typedef enum logic [1:0] {PRED_BAD, PRED_ALWAYS, PRED_IF_SET, PRED_IF_CLR} pred_e;

  typedef struct packed {
    logic       legal;
    lop_e       op;
    pred_e      pred;
    logic [1:0] src_x;
    logic [1:0] src_y;
    logic [3:0] dst;
  } dec_t;
endpackage

// File: rtl/dlu_decode.sv
module dlu_decode
  import dlu_pkg::*;
(
  input  logic [15:0] word2,
  output dec_t        dec
);
  lop_e  op;
  pred_e pred;

  always_comb begin
    case (word2[15:10])
      6'b100101: op = LOP_AND;
      6'b101101: op = LOP_OR;
      6'b101001: op = LOP_XOR;
      default:   op = LOP_NONE;
    endcase
    case (word2[9:8])
      2'b01:   pred = PRED_ALWAYS;
      2'b10:   pred = PRED_IF_SET;
      2'b11:   pred = PRED_IF_CLR;
      default: pred = PRED_BAD;
    endcase
    dec.op    = op;
    dec.pred  = pred;
    dec.legal = (op != LOP_NONE) && (pred != PRED_BAD);
    dec.src_x = word2[7:6];
    dec.src_y = word2[5:4];
    dec.dst   = word2[3:0];
  end
endmodule

// File: rtl/dlu_alu.sv
module dlu_alu
  import dlu_pkg::*;
#(
  parameter int HW = 16
) (
  input  lop_e          op,
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  output logic [HW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (op)
      LOP_AND: y = a & b;
      LOP_OR:  y = a | b;
      LOP_XOR: y = a ^ b;
      default: y = '0;
    endcase
    zero = (y == '0);
  end
endmodule

// File: rtl/dlu_regfile.sv
module dlu_regfile #(
  parameter int NUM_REGS = 8,
  parameter int W        = 32,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int HW      = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_we,
  input  logic [3:0]    op_addr,
  input  logic [W-1:0]  op_data,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic [1:0]    ra_x,
  input  logic [1:0]    ra_y,
  input  logic [AW-1:0] ra_d,
  output logic [HW-1:0] x_hi,
  output logic [HW-1:0] y_hi,
  output logic [W-1:0]  d_out
);
  logic [W-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [3:0]    OP_IDX = 4'(i);
    localparam logic [AW-1:0] LD_IDX = AW'(i);
    always_ff @(posedge clk) begin
      if (rst)
        mem[i] <= '0;
      else if (op_we && op_addr == OP_IDX)
        mem[i] <= op_data;
      else if (ld_we && ld_addr == LD_IDX)
        mem[i] <= ld_data;
    end
  end

  logic [W-1:0] x_full, y_full;
  assign x_full = mem[AW'(ra_x)];
  assign y_full = mem[AW'(ra_y)];
  assign x_hi   = x_full[W-1:HW];
  assign y_hi   = y_full[W-1:HW];
  assign d_out  = mem[ra_d];

  logic unused_lo;
  assign unused_lo = ^{x_full[HW-1:0], y_full[HW-1:0]};
endmodule

// File: rtl/dlu_top.sv
module dlu_top
  import dlu_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int W       = 32,
  localparam int HW      = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_word1,
  input  logic [15:0]   in_word2,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          flag_o,
  output logic          illegal_o
);
  dec_t          dec;
  logic          accept, exec, res_zero;
  logic [HW-1:0] x_hi, y_hi, res;
  logic          flag_q, illegal_q;

  assign in_ready = 1'b1;
  assign accept   = in_valid && (in_word1[15:10] == PREFIX);

  dlu_decode u_dec (.word2(in_word2), .dec(dec));

  always_comb begin
    exec = 1'b0;
    if (accept && dec.legal) begin
      case (dec.pred)
        PRED_ALWAYS: exec = 1'b1;
        PRED_IF_SET: exec = flag_q;
        PRED_IF_CLR: exec = !flag_q;
        default:     exec = 1'b0;
      endcase
    end
  end

  dlu_regfile #(.NUM_REGS(NUM_REGS), .W(W)) u_rf (
    .clk(clk), .rst(rst),
    .op_we(exec), .op_addr(dec.dst), .op_data({res, {HW{1'b0}}}),
    .ld_we(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .ra_x(dec.src_x), .ra_y(dec.src_y), .ra_d(rd_addr),
    .x_hi(x_hi), .y_hi(y_hi), .d_out(rd_data)
  );

  dlu_alu #(.HW(HW)) u_alu (
    .op(dec.op), .a(x_hi), .b(y_hi), .y(res), .zero(res_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !dec.legal;
      if (accept && dec.legal && dec.pred == PRED_ALWAYS)
        flag_q <= res_zero;
    end
  end

  assign flag_o    = flag_q;
  assign illegal_o = illegal_q;

  logic unused_w1;
  assign unused_w1 = ^in_word1[9:0];
endmodule

// File: rtl/dlu_checker.sv
module dlu_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_word1,
  input logic [15:0] in_word2,
  input logic        flag_o,
  input logic        illegal_o
);
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  assert_pulse_needs_prefix_R1: assert property (@(posedge clk) disable iff (rst)
    (illegal_o && !$past(rst)) |-> $past(in_valid && in_word1[15:10] == 6'b111110));

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (illegal_o && !$past(rst)) |-> (!$past(illegal_o) || $past(in_valid)));

  assert_flag_only_uncond_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid && in_word1[15:10] == 6'b111110
                          && in_word2[9:8] == 2'b01)) |-> $stable(flag_o));

  assert_legal_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && in_word2[9:8] == 2'b01
                          && in_word2[15:10] == 6'b100101)) |-> !illegal_o);
endmodule

bind dlu_top dlu_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word1(in_word1), .in_word2(in_word2),
  .flag_o(flag_o), .illegal_o(illegal_o)
);

// File: tb/test_dlu_top.sv
`timescale 1ns/10ps
module test_dlu_top;
  localparam int N  = 8;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [15:0]   in_word1, in_word2;
  logic          ld_en;
  logic [AW-1:0] ld_addr;
  logic [31:0]   ld_data;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          flag_o, illegal_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_reg [N];
  logic        m_flag;
  logic        wd_hit = 1'b0;

  always #2 clk = ~clk;

  dlu_top #(.NUM_REGS(N)) i_dlu_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word1(in_word1), .in_word2(in_word2),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_o(flag_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fam(input int f);
    case (f)
      0: return 6'b100101;
      1: return 6'b101101;
      default: return 6'b101001;
    endcase
  endfunction

  function automatic logic [15:0] calc(input int f, input logic [15:0] a, input logic [15:0] b);
    case (f)
      0: return a & b;
      1: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic idle();
    in_valid = 1'b0; ld_en = 1'b0;
    in_word1 = 16'h0; in_word2 = 16'h0;
  endtask

  task automatic load(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(posedge clk); #0.5;
    idle();
    m_reg[a] = d;
  endtask

  // Issue one op; model updated per R1..R8, R11 (optional load on same edge)
  task automatic issue(input logic [15:0] w1, input logic [15:0] w2,
                       input bit with_ld, input int la, input logic [31:0] ld);
    logic pfx, legal, ex;
    int f;
    logic [15:0] r;
    pfx = (w1[15:10] == 6'b111110);
    f = (w2[15:10] == 6'b100101) ? 0 : (w2[15:10] == 6'b101101) ? 1 :
        (w2[15:10] == 6'b101001) ? 2 : 3;
    legal = (f != 3) && (w2[9:8] != 2'b00);
    ex = pfx && legal && (w2[9:8] == 2'b01 || (w2[9:8] == 2'b10 && m_flag) ||
                          (w2[9:8] == 2'b11 && !m_flag));
    r = (f == 3) ? 16'h0 : calc(f, m_reg[w2[7:6]][31:16], m_reg[w2[5:4]][31:16]);
    @(negedge clk);
    in_valid = 1'b1; in_word1 = w1; in_word2 = w2;
    ld_en = with_ld; ld_addr = AW'(la); ld_data = ld;
    @(posedge clk); #0.5;
    idle();
    if (with_ld) m_reg[la] = ld;
    if (ex && int'(w2[3:0]) < N) m_reg[w2[3:0]] = {r, 16'h0};
    if (pfx && legal && w2[9:8] == 2'b01) m_flag = (r == 16'h0);
    chk("R6 flag", {31'h0, flag_o}, {31'h0, m_flag});
    chk("R8 illegal pulse", {31'h0, illegal_o}, {31'h0, pfx && !legal});
    chk("R9 ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < N; i++) begin
      rd_addr = AW'(i);
      #0.2;
      chk(req, rd_data, m_reg[i]);
    end
  endtask

  function automatic logic [15:0] w2of(input int f, input logic [1:0] p,
                                       input int x, input int y, input int d);
    return {fam(f), p, 2'(x), 2'(y), 4'(d)};
  endfunction

  initial begin
    #(4.0 * 150000);
    wd_hit = 1'b1;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    idle(); ld_addr = '0; ld_data = '0; rd_addr = '0;
    rst = 1'b1;
    for (int i = 0; i < N; i++) m_reg[i] = 32'h0;
    m_flag = 1'b0;
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;
    // R10 reset state
    chk("R10 flag reset", {31'h0, flag_o}, 32'h0);
    chk("R10 illegal reset", {31'h0, illegal_o}, 32'h0);
    check_regs("R10 regs reset");

    // R11 loads
    load(0, 32'hF0F0_1234); load(1, 32'h0FF0_ABCD);
    load(2, 32'h0000_FFFF); load(3, 32'hFFFF_0001);
    check_regs("R11 load");

    // R2 R3 R4: each function, lower half cleared
    issue(16'hF800, w2of(0, 2'b01, 0, 1, 4), 0, 0, 0); check_regs("R4 AND");
    issue(16'hFBFF, w2of(1, 2'b01, 1, 2, 5), 0, 0, 0); check_regs("R2 OR");
    issue(16'hF955, w2of(2, 2'b01, 3, 0, 6), 0, 0, 0); check_regs("R3 XOR sources");
    // R6 zero result from non-zero lower halves sets flag
    issue(16'hF800, w2of(0, 2'b01, 2, 3, 7), 0, 0, 0);
    chk("R6 zero sets flag", {31'h0, flag_o}, 32'h1);
    check_regs("R4 zero result");
    // R5 if-set runs with flag 1, if-clear skipped
    issue(16'hF800, w2of(1, 2'b10, 0, 1, 4), 0, 0, 0); check_regs("R5 if-set taken");
    issue(16'hF800, w2of(2, 2'b11, 0, 3, 5), 0, 0, 0); check_regs("R5 if-clear skipped");
    // clear flag, then opposite
    issue(16'hF800, w2of(1, 2'b01, 0, 0, 15), 0, 0, 0);
    chk("R6 unused dest still updates flag", {31'h0, flag_o}, 32'h0);
    check_regs("R7 unused dest");
    issue(16'hF800, w2of(0, 2'b10, 0, 1, 6), 0, 0, 0); check_regs("R5 if-set skipped");
    issue(16'hF800, w2of(2, 2'b11, 0, 1, 6), 0, 0, 0); check_regs("R5 if-clear taken");
    // R7 dest 8..15
    issue(16'hF800, w2of(2, 2'b01, 0, 1, 8), 0, 0, 0); check_regs("R7 dest 8");
    // R8 illegal form / family and one-cycle pulse
    issue(16'hF800, {fam(0), 2'b00, 8'h14}, 0, 0, 0);
    check_regs("R8 illegal no-op");
    issue(16'h0000, 16'h0000, 0, 0, 0);
    chk("R8 pulse ends", {31'h0, illegal_o}, 32'h0);
    issue(16'hF800, {6'b111111, 2'b01, 8'h14}, 0, 0, 0);
    // R1 wrong prefix: no execution, no pulse
    issue(16'hF400, w2of(1, 2'b01, 0, 1, 2), 0, 0, 0);
    chk("R1 no pulse", {31'h0, illegal_o}, 32'h0);
    check_regs("R1 prefix mismatch");
    // R11 collision: operation wins
    issue(16'hF800, w2of(1, 2'b01, 0, 1, 3), 1, 3, 32'h1234_5678);
    check_regs("R11 op over load");
    issue(16'hF800, w2of(1, 2'b01, 0, 1, 3), 1, 2, 32'h0000_5678);
    check_regs("R11 load other reg");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind;
      kind = int'($urandom_range(0, 9));
      if (kind < 3) begin
        logic [31:0] d;
        d = $urandom;
        if ($urandom_range(0, 3) == 0) d[31:16] = 16'h0;
        load(int'($urandom_range(0, N - 1)), d);
      end else begin
        logic [15:0] w1, w2;
        w1 = {6'b111110, 10'($urandom)};
        if ($urandom_range(0, 15) == 0) w1[15:10] = 6'($urandom);
        w2 = w2of(int'($urandom_range(0, 2)), 2'($urandom_range(1, 3)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 15)));
        if ($urandom_range(0, 15) == 0) w2 = 16'($urandom);
        issue(w1, w2, $urandom_range(0, 4) == 0, int'($urandom_range(0, N - 1)), $urandom);
      end
      check_regs("R4 random");
    end

    if (!wd_hit) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule